// File: doc/BRIEF.md
# Read-Only NAND Flash Device Responder

This block sits on the device side of a small-page NAND flash bus and answers reads from a host controller. It watches an 8-bit bidirectional data bus together with active-low chip-enable, read-strobe and write-strobe inputs and active-high command-latch and address-latch inputs. Command bytes choose one of three read modes. Three address bytes then set a linear byte pointer into an array of 528-byte pages. Each read strobe returns the byte under the pointer and then moves the pointer forward by one.

Two chip-enable lanes select between two independent responders. Each lane has its own mode, pointer and sticky error flag. Every bus input passes through a two-stage synchroniser to an internal clock. A command or address byte is taken on the rising edge of the write strobe, and a read is served on the falling edge of the read strobe. The array contents are computed rather than stored. With the default image mode every location reads as erased (0xFF). A signature image mode gives each location a value derived from its own pointer, so that a bench or a boot check can confirm which byte was addressed.

Top module: `nand_rd_responder`

## Requirements
- R1: After reset the bus is released (`drive_o` low), both ready bits are low and both error flags are clear.
- R2: Command 0x00 followed by address bytes C, H, L sets the pointer to C + (H*256 + L)*528. The first read then returns the image byte at that pointer.
- R3: Command 0x01 adds 256 to the column, giving 256 + C + (H*256 + L)*528. Command 0x50 adds 512 to the column, giving 512 + C + (H*256 + L)*528.
- R4: Each read strobe advances the pointer of the selected lane by one, so consecutive reads return consecutive locations.
- R5: Command 0xFF returns the lane to idle. An address byte received while idle sets that lane's error flag.
- R6: A command byte other than 0xFF, 0x00, 0x01 or 0x50 sets the lane's error flag and forces idle. The flag stays set through later valid commands and reads, and only reset clears it. Reads keep working while the flag is set.
- R7: A fourth address byte after a read command sets the lane's error flag. Three address bytes do not set it.
- R8: `ce0_ni` low selects lane 0, even when `ce1_ni` is also low. Lane 1 is selected only when `ce0_ni` is high and `ce1_ni` is low. The two lanes keep independent pointers.
- R9: With both chip enables high, strobes change no state and the bus is not driven.
- R10: While a lane is selected and both strobes are high, its bit of `rdy_o` is set (bit 0 for lane 0, bit 1 for lane 1), the other bit is clear, and the bus is released.
- R11: In the erased image mode every location reads 0xFF. In both modes a pointer at or beyond PAGE_BYTES*NUM_PAGES reads 0xFF.
- R12: The image byte is driven on `data_io` with `drive_o` high no later than the fourth clock edge after the read strobe falls, and it is held while the strobe stays low. In signature mode the byte at pointer P of lane n is P[7:0]^P[15:8]^P[23:16]^{6'b0,P[25:24]}, further XORed with 0x5A for lane 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce0_ni | input | 1 | Chip enable for lane 0, active low |
| ce1_ni | input | 1 | Chip enable for lane 1, active low |
| re_ni | input | 1 | Read strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| data_io | inout | 8 | Bidirectional data bus |
| drive_o | output | 1 | High while the block drives data_io |
| rdy_o | output | 2 | Per-lane ready |
| err_o | output | 2 | Per-lane sticky protocol error |

## Verification
The hardest state to reach from the ports is a lane whose error flag is set while it still holds a valid read pointer. This state is what shows that the flag is sticky and yet does not block reads. The stimulus first sends an unknown command to lane 1, then a full valid read command with three address bytes, then a read. Lane independence is also hard to see. The bench interleaves lane 1 traffic with lane 0 reads and confirms that lane 0 resumes from its own pointer. It also sends strobes while neither lane is selected and checks that no pointer moved.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  typedef enum logic [1:0] {ST_WAIT, ST_RD1, ST_RD2, ST_RD3} rd_state_e;

  localparam logic [7:0] CMD_IDLE = 8'hFF;
  localparam logic [7:0] CMD_RD1  = 8'h00;
  localparam logic [7:0] CMD_RD2  = 8'h01;
  localparam logic [7:0] CMD_RD3  = 8'h50;
endpackage

// File: rtl/nand_bus_sync.sv
module nand_bus_sync #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/nand_array.sv
module nand_array #(
  parameter int PTR_W       = 26,
  parameter int ARRAY_BYTES = 528 * 32768,
  parameter int IMAGE_MODE  = 0,
  parameter int LANE        = 0
) (
  input  logic [PTR_W-1:0] addr_i,
  output logic [7:0]       byte_o
);
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(ARRAY_BYTES);
  localparam logic [7:0]       SALT  = (LANE == 0) ? 8'h00 : 8'h5A;

  logic [31:0] addr_ext;
  logic [7:0]  sig;
  logic        in_range;

  assign addr_ext = 32'(addr_i);
  assign in_range = addr_i < LIMIT;

  generate
    if (IMAGE_MODE != 0) begin : g_sig
      assign sig = addr_ext[7:0] ^ addr_ext[15:8] ^ addr_ext[23:16] ^ {6'b0, addr_ext[25:24]} ^ SALT;
    end else begin : g_erased
      assign sig = 8'hFF;
    end
  endgenerate

  // addr_ext[31:26] only matters when PTR_W is widened
  assign byte_o = (in_range && (addr_ext[31:26] == 6'd0)) ? sig : 8'hFF;
endmodule

// File: rtl/nand_lane.sv
module nand_lane
  import nand_rd_pkg::*;
#(
  parameter int PAGE_BYTES = 528,
  parameter int PTR_W      = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_stb_i,
  input  logic             addr_stb_i,
  input  logic             rd_stb_i,
  input  logic [7:0]       byte_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             err_o
);
  localparam logic [PTR_W-1:0] W_HI   = PTR_W'(PAGE_BYTES * 256);
  localparam logic [PTR_W-1:0] W_LO   = PTR_W'(PAGE_BYTES);
  localparam logic [PTR_W-1:0] OFF_R2 = PTR_W'(256);
  localparam logic [PTR_W-1:0] OFF_R3 = PTR_W'(512);

  rd_state_e        st_q;
  logic [1:0]       cyc_q;
  logic [PTR_W-1:0] ptr_q;
  logic             err_q;
  logic [PTR_W-1:0] byte_ext, col_off;

  assign byte_ext = PTR_W'(byte_i);
  assign col_off  = (st_q == ST_RD2) ? OFF_R2 :
                    (st_q == ST_RD3) ? OFF_R3 : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_WAIT;
      cyc_q <= 2'd0;
      ptr_q <= '0;
      err_q <= 1'b0;
    end else if (cmd_stb_i) begin
      unique case (byte_i)
        CMD_IDLE: st_q <= ST_WAIT;
        CMD_RD1:  begin st_q <= ST_RD1; cyc_q <= 2'd0; end
        CMD_RD2:  begin st_q <= ST_RD2; cyc_q <= 2'd0; end
        CMD_RD3:  begin st_q <= ST_RD3; cyc_q <= 2'd0; end
        default:  begin st_q <= ST_WAIT; err_q <= 1'b1; end
      endcase
    end else if (addr_stb_i) begin
      if (st_q == ST_WAIT || cyc_q == 2'd3) begin
        st_q  <= ST_WAIT;
        err_q <= 1'b1;
      end else begin
        unique case (cyc_q)
          2'd0:    ptr_q <= byte_ext + col_off;
          2'd1:    ptr_q <= ptr_q + byte_ext * W_HI;
          default: ptr_q <= ptr_q + byte_ext * W_LO;
        endcase
        cyc_q <= cyc_q + 2'd1;
      end
    end else if (rd_stb_i) begin
      ptr_q <= ptr_q + PTR_W'(1);
    end
  end

  assign ptr_o = ptr_q;
  assign err_o = err_q;

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_ptr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !cmd_stb_i && !addr_stb_i) |=> ptr_q == $past(ptr_q) + PTR_W'(1));
  p_idle_cmd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb_i && byte_i == CMD_IDLE) |=> st_q == ST_WAIT);
  p_fourth_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_stb_i && !cmd_stb_i && cyc_q == 2'd3) |=> err_q);
endmodule

// File: rtl/nand_rd_responder.sv
module nand_rd_responder #(
  parameter int PAGE_BYTES = 528,
  parameter int NUM_PAGES  = 32768,
  parameter int IMAGE_MODE = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce0_ni,
  input  logic       ce1_ni,
  input  logic       re_ni,
  input  logic       we_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  inout  wire  [7:0] data_io,
  output logic       drive_o,
  output logic [1:0] rdy_o,
  output logic [1:0] err_o
);
  localparam int LANES       = 2;
  localparam int PTR_W       = $clog2(PAGE_BYTES * 65536);
  localparam int ARRAY_BYTES = PAGE_BYTES * NUM_PAGES;
  localparam int SW          = 14;
  // {ce1, ce0, re, we, cle, ale, data}
  localparam logic [SW-1:0] SYNC_RST = {4'b1111, 2'b00, 8'h00};

  logic [SW-1:0] raw, syn;
  logic ce1_s, ce0_s, re_s, we_s, cle_s, ale_s;
  logic [7:0] dat_s;
  logic re_p, we_p;

  assign raw = {ce1_ni, ce0_ni, re_ni, we_ni, cle_i, ale_i, data_io};

  nand_bus_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i, .rst_ni, .async_i(raw), .sync_o(syn)
  );

  assign {ce1_s, ce0_s, re_s, we_s, cle_s, ale_s, dat_s} = syn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_p <= 1'b1;
      we_p <= 1'b1;
    end else begin
      re_p <= re_s;
      we_p <= we_s;
    end
  end

  logic we_rise, re_fall, sel_any;
  logic [LANES-1:0] sel;
  assign we_rise = we_s & ~we_p;
  assign re_fall = ~re_s & re_p;
  assign sel[0]  = ~ce0_s;
  assign sel[1]  = ce0_s & ~ce1_s;
  assign sel_any = |sel;

  logic cmd_stb, addr_stb, rd_stb;
  assign cmd_stb  = we_rise & cle_s;
  assign addr_stb = we_rise & ~cle_s & ale_s;
  assign rd_stb   = re_fall & ~cle_s & ~ale_s;

  logic [PTR_W-1:0] ptr   [LANES];
  logic [7:0]       img   [LANES];
  logic [LANES-1:0] err;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    nand_lane #(.PAGE_BYTES(PAGE_BYTES), .PTR_W(PTR_W)) u_lane (
      .clk_i,
      .rst_ni,
      .cmd_stb_i (cmd_stb  & sel[g]),
      .addr_stb_i(addr_stb & sel[g]),
      .rd_stb_i  (rd_stb   & sel[g]),
      .byte_i    (dat_s),
      .ptr_o     (ptr[g]),
      .err_o     (err[g])
    );
    nand_array #(.PTR_W(PTR_W), .ARRAY_BYTES(ARRAY_BYTES),
                 .IMAGE_MODE(IMAGE_MODE), .LANE(g)) u_arr (
      .addr_i(ptr[g]),
      .byte_o(img[g])
    );
  end

  logic [7:0]       dout_q;
  logic             drive_q;
  logic [LANES-1:0] rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= 8'h00;
      drive_q <= 1'b0;
      rdy_q   <= '0;
    end else begin
      rdy_q <= sel & {LANES{re_s & we_s}};
      if (!sel_any || (re_s && we_s)) begin
        drive_q <= 1'b0;
      end else if (rd_stb) begin
        dout_q  <= sel[0] ? img[0] : img[1];
        drive_q <= 1'b1;
      end
    end
  end

  assign data_io = drive_q ? dout_q : 8'hzz;
  assign drive_o = drive_q;
  assign rdy_o   = rdy_q;
  assign err_o   = err;

  p_deselect_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_any |=> !drive_q);
  p_rdy_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rdy_q));
  p_idle_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_s && we_s) |=> !drive_q);
  p_hold_drive_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_q && sel_any && !re_s) |=> drive_q);
endmodule

// File: tb/tb_nand_rd_responder.sv
module tb_nand_rd_responder;
  localparam int PB  = 528;
  localparam int ARR = 528 * 32768;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce0_n = 1'b1, ce1_n = 1'b1, re_n = 1'b1, we_n = 1'b1, cle = 1'b0, ale = 1'b0;
  logic [7:0] drv = 8'h00;
  logic drv_en = 1'b0;
  wire  [7:0] bus_a, bus_b;
  logic drive_a, drive_b;
  logic [1:0] rdy_a, rdy_b, err_a, err_b;

  int n_total = 0, n_fail = 0, cyc = 0;
  int exp_ptr [2];

  always #4 clk = ~clk;

  assign bus_a = drv_en ? drv : 8'hzz;
  assign bus_b = drv_en ? drv : 8'hzz;

  nand_rd_responder #(.IMAGE_MODE(1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce0_ni(ce0_n), .ce1_ni(ce1_n), .re_ni(re_n),
    .we_ni(we_n), .cle_i(cle), .ale_i(ale), .data_io(bus_a),
    .drive_o(drive_a), .rdy_o(rdy_a), .err_o(err_a)
  );

  nand_rd_responder #(.IMAGE_MODE(0)) dut_erased (
    .clk_i(clk), .rst_ni(rst_n), .ce0_ni(ce0_n), .ce1_ni(ce1_n), .re_ni(re_n),
    .we_ni(we_n), .cle_i(cle), .ale_i(ale), .data_io(bus_b),
    .drive_o(drive_b), .rdy_o(rdy_b), .err_o(err_b)
  );

  function automatic logic [7:0] sig(int p, int lane);
    logic [31:0] a;
    a = 32'(p);
    if (p >= ARR) return 8'hFF;
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ {6'b0, a[25:24]} ^ (lane == 1 ? 8'h5A : 8'h00);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=0x%0h expected=0x0", cyc);
      finish_run();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ce0_n = 1'b1; ce1_n = 1'b1; re_n = 1'b1; we_n = 1'b1;
    cle = 1'b0; ale = 1'b0; drv_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    exp_ptr[0] = 0;
    exp_ptr[1] = 0;
  endtask

  task automatic pick(int l);
    @(negedge clk);
    ce0_n = !(l == 0 || l == 2);
    ce1_n = !(l == 1 || l == 2);
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(bit is_cmd, logic [7:0] b);
    @(negedge clk);
    cle = is_cmd; ale = !is_cmd; drv = b; drv_en = 1'b1;
    @(negedge clk); we_n = 1'b0;
    repeat (3) @(negedge clk); we_n = 1'b1;
    repeat (4) @(negedge clk);
    cle = 1'b0; ale = 1'b0; drv_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] a, output logic [7:0] b, output logic d);
    @(negedge clk); re_n = 1'b0;
    repeat (4) @(negedge clk);
    a = bus_a; b = bus_b; d = drive_a;
    re_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_check(int lane, string req);
    logic [7:0] a, b;
    logic d;
    rd(a, b, d);
    check(a == sig(exp_ptr[lane], lane), req, a, sig(exp_ptr[lane], lane));
    check(d == 1'b1, "R12", d, 1);
    check(b == 8'hFF, "R11", b, 8'hFF);
    exp_ptr[lane]++;
  endtask

  task automatic seq(int lane, logic [7:0] cmd, logic [7:0] c, logic [7:0] h, logic [7:0] l, int off);
    pick(lane);
    wr(1, cmd); wr(0, c); wr(0, h); wr(0, l);
    exp_ptr[lane] = off + int'(c) + (int'(h) * 256 + int'(l)) * PB;
  endtask

  task automatic t_reset();
    check(drive_a == 1'b0, "R1", drive_a, 0);
    check(rdy_a == 2'b00, "R1", rdy_a, 0);
    check(err_a == 2'b00, "R1", err_a, 0);
  endtask

  task automatic t_ready();
    pick(0);
    repeat (4) @(negedge clk);
    check(rdy_a == 2'b01, "R10", rdy_a, 1);
    check(drive_a == 1'b0, "R10", drive_a, 0);
    pick(1);
    repeat (4) @(negedge clk);
    check(rdy_a == 2'b10, "R10", rdy_a, 2);
  endtask

  task automatic t_mode1();
    seq(0, 8'h00, 8'h12, 8'h01, 8'h03, 0);
    for (int i = 0; i < 3; i++) rd_check(0, (i == 0) ? "R2" : "R4");
  endtask

  task automatic t_modes();
    seq(0, 8'h01, 8'h05, 8'h00, 8'h02, 256);
    rd_check(0, "R3");
    seq(0, 8'h50, 8'h07, 8'h00, 8'h00, 512);
    rd_check(0, "R3");
    rd_check(0, "R4");
  endtask

  task automatic t_lanes();
    seq(1, 8'h00, 8'h20, 8'h00, 8'h01, 0);
    rd_check(1, "R8");
    rd_check(1, "R8");
    pick(2);
    rd_check(0, "R8");
  endtask

  task automatic t_deselect();
    logic [7:0] a, b;
    logic d;
    pick(3);
    wr(1, 8'h00); wr(0, 8'h44);
    rd(a, b, d);
    check(d == 1'b0, "R9", d, 0);
    check(rdy_a == 2'b00, "R9", rdy_a, 0);
    pick(0);
    rd_check(0, "R9");
  endtask

  task automatic t_beyond();
    seq(0, 8'h00, 8'h00, 8'hFF, 8'h00, 0);
    rd_check(0, "R11");
  endtask

  task automatic t_err_idle();
    do_reset();
    pick(0);
    wr(1, 8'hFF);
    check(err_a == 2'b00, "R5", err_a, 0);
    wr(0, 8'h00);
    check(err_a == 2'b01, "R5", err_a, 1);
  endtask

  task automatic t_err_unknown();
    do_reset();
    pick(1);
    wr(1, 8'h30);
    check(err_a == 2'b10, "R6", err_a, 2);
    seq(1, 8'h00, 8'h00, 8'h00, 8'h00, 0);
    rd_check(1, "R6");
    check(err_a == 2'b10, "R6", err_a, 2);
  endtask

  task automatic t_err_fourth();
    do_reset();
    seq(0, 8'h00, 8'h01, 8'h00, 8'h00, 0);
    check(err_a == 2'b00, "R7", err_a, 0);
    wr(0, 8'h09);
    check(err_a == 2'b01, "R7", err_a, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_ready();
    t_mode1();
    t_modes();
    t_lanes();
    t_deselect();
    t_beyond();
    t_err_idle();
    t_err_unknown();
    t_err_fourth();
    finish_run();
  end
endmodule